// File: doc/BRIEF.md
# JTAG Configuration Store Command Controller

This block sits behind a boundary-scan TAP state machine and carries out configuration commands on a small store. The store holds a configuration word, a signature word and a one-bit security flag. The TAP supplies single-cycle strobes for Update-IR, Update-DR, entry into Run-Test/Idle and Test-Logic-Reset. It also supplies the latched 4-bit instruction and the shifted data word. Update-DR captures that data word into a holding register, and the program commands use the holding register.

Commands that change the store, the live configuration, the power state or the calibration state are held pending at Update-IR. They run only when the TAP next enters Run-Test/Idle. Read-select instructions act at Update-IR, so the TAP can keep shifting without leaving its inner loop.

Programming can only set bits. The two word erases clear one word each. A bulk erase returns every user bit to zero, and it is the only way to clear the security flag. A live configuration register feeds the rest of the chip. It is loaded only by the latch and reload commands, so erasing the store never disturbs operation.

Top module: `jtag_cfg_cmd_ctrl`

## Requirements
- R1: Instruction codes 1..11 are deferred. Update-IR only records them as pending, and none of them changes any output. A pending command runs on the clock edge that samples `rti_entry` high, and its result is visible in the next cycle. A pending command is consumed by that Run-Test/Idle entry whether or not it runs.
- R2: Code 12 selects configuration readback and code 13 selects signature readback on `rd_data`. Both take effect on the clock edge that samples `upd_ir`. After reset, configuration readback is selected.
- R3: Program-config (code 1) and program-signature (code 2) store the old word OR the data captured at the last Update-DR, so bits only go from 0 to 1.
- R4: Erase-config (code 4) clears only the configuration word. Erase-signature (code 5) clears only the signature word.
- R5: Bulk erase (code 6) clears the configuration word, the signature word and the security flag on the same edge. No other command clears the security flag.
- R6: Program-security (code 3) sets `secure`. While `secure` is set, configuration readback returns zero, and signature readback still works.
- R7: Latch (code 7) and reload (code 8) copy the stored configuration word to `live_cfg`. The erase commands leave `live_cfg` unchanged.
- R8: Program and erase commands (codes 1 to 6) raise `busy` for BUSY_CYC cycles, starting in the cycle after they run. A deferred command whose Run-Test/Idle entry is sampled while `busy` is high is dropped.
- R9: Power-down (code 10) sets `pwr_down` and drops `out_en`. Power-up (code 9) reverses both. Readback keeps working while powered down.
- R10: Calibrate (code 11) raises `cal_busy` for CAL_CYC cycles, and Test-Logic-Reset does not shorten this. A calibrate command that runs while `cal_busy` is high is ignored.
- R11: Test-Logic-Reset discards a pending command. Reset clears all words and flags, sets `out_en` high and selects configuration readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_ir | input | 1 | Update-IR strobe |
| upd_dr | input | 1 | Update-DR strobe, captures `shift_data` |
| rti_entry | input | 1 | Strobe on entry into Run-Test/Idle |
| tlr | input | 1 | Test-Logic-Reset strobe |
| instr | input | 4 | Latched instruction code |
| shift_data | input | DATA_W | Shifted data word |
| rd_data | output | DATA_W | Selected readback word |
| live_cfg | output | DATA_W | Active configuration |
| secure | output | 1 | Security flag |
| busy | output | 1 | Program/erase in progress |
| cal_busy | output | 1 | Calibration running |
| pwr_down | output | 1 | Low-power state |
| out_en | output | 1 | Output enable, low when powered down |

## Verification
Every result is registered once. A deferred command is seen in the cycle after its `rti_entry` strobe, and a read select is seen in the cycle after its `upd_ir` strobe. `busy` and `cal_busy` rise in that same cycle and fall BUSY_CYC or CAL_CYC cycles later. The bench drives its inputs just after the rising edge. It steps a behavioural model on each rising edge and compares every output on the falling edge, so each result is checked in the exact cycle it is due. Directed checks with fixed values cover the ordering cases. These include a command dropped while busy, a pending command cancelled by Test-Logic-Reset, and calibration continuing through Test-Logic-Reset.

// File: rtl/jtag_cfg_cmd_ctrl.sv
module jtag_cfg_cmd_ctrl #(
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 8,
  parameter int CAL_CYC  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_ir,
  input  logic              upd_dr,
  input  logic              rti_entry,
  input  logic              tlr,
  input  logic [3:0]        instr,
  input  logic [DATA_W-1:0] shift_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] live_cfg,
  output logic              secure,
  output logic              busy,
  output logic              cal_busy,
  output logic              pwr_down,
  output logic              out_en
);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam int CW = $clog2(CAL_CYC + 1);

  localparam logic [3:0] C_PCFG = 4'd1, C_PSIG = 4'd2, C_PSEC = 4'd3,
                         C_ECFG = 4'd4, C_ESIG = 4'd5, C_BULK = 4'd6,
                         C_LTCH = 4'd7, C_RLD  = 4'd8, C_PUP  = 4'd9,
                         C_PDN  = 4'd10, C_CAL = 4'd11,
                         C_RCFG = 4'd12, C_RSIG = 4'd13;

  logic [DATA_W-1:0] cfg_st, sig_st, dreg;
  logic [3:0]        pend_op;
  logic              pend_vld, sel_sig;
  logic [BW-1:0]     bcnt;
  logic [CW-1:0]     ccnt;

  wire go      = rti_entry && pend_vld && (bcnt == '0);
  wire is_def  = (instr >= C_PCFG) && (instr <= C_CAL);
  wire nv_op   = (pend_op >= C_PCFG) && (pend_op <= C_BULK);
  wire is_ers  = (pend_op == C_ECFG) || (pend_op == C_ESIG) || (pend_op == C_BULK);

  assign busy     = (bcnt != '0);
  assign cal_busy = (ccnt != '0);
  assign out_en   = ~pwr_down;
  assign rd_data  = sel_sig ? sig_st : (secure ? '0 : cfg_st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_op  <= '0;
      sel_sig  <= 1'b0;
      dreg     <= '0;
    end else begin
      if (upd_dr) dreg <= shift_data;
      if (tlr) pend_vld <= 1'b0;
      else if (upd_ir) begin
        pend_vld <= is_def;
        pend_op  <= instr;
        if (instr == C_RCFG) sel_sig <= 1'b0;
        if (instr == C_RSIG) sel_sig <= 1'b1;
      end else if (rti_entry) pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      ccnt <= '0;
    end else begin
      if (go && nv_op) bcnt <= BW'(BUSY_CYC);
      else if (bcnt != '0) bcnt <= bcnt - 1'b1;
      if (go && pend_op == C_CAL && ccnt == '0) ccnt <= CW'(CAL_CYC);
      else if (ccnt != '0) ccnt <= ccnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_st   <= '0;
      sig_st   <= '0;
      secure   <= 1'b0;
      live_cfg <= '0;
      pwr_down <= 1'b0;
    end else if (go) begin
      case (pend_op)
        C_PCFG: cfg_st <= cfg_st | dreg;
        C_PSIG: sig_st <= sig_st | dreg;
        C_PSEC: secure <= 1'b1;
        C_ECFG: cfg_st <= '0;
        C_ESIG: sig_st <= '0;
        C_BULK: begin
          cfg_st <= '0;
          sig_st <= '0;
          secure <= 1'b0;
        end
        C_LTCH, C_RLD: live_cfg <= cfg_st;
        C_PUP:  pwr_down <= 1'b0;
        C_PDN:  pwr_down <= 1'b1;
        default: ;
      endcase
    end
  end

  a_r1_no_exec_at_upd_ir: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ir && !rti_entry |=> $stable(cfg_st) && $stable(sig_st) && $stable(pwr_down) && $stable(live_cfg));

  a_r3_program_sets_only: assert property (@(posedge clk) disable iff (!rst_n)
    go && pend_op == C_PCFG |=> cfg_st == ($past(cfg_st) | $past(dreg)));

  a_r5_secure_clear_by_bulk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secure) |-> $past(go && pend_op == C_BULK));

  a_r7_erase_keeps_live: assert property (@(posedge clk) disable iff (!rst_n)
    go && is_ers |=> $stable(live_cfg));

  a_r8_drop_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rti_entry && !upd_ir |=> $stable(cfg_st) && $stable(sig_st) && $stable(secure) && $stable(pwr_down));

  a_r10_cal_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
    ccnt > CW'(1) |=> cal_busy);
endmodule

// File: tb/sim_jtag_cfg_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_jtag_cfg_cmd_ctrl;
  localparam int W = 16, BC = 8, CC = 24;
  logic clk = 0, rst_n = 0, upd_ir = 0, upd_dr = 0, rti_entry = 0, tlr = 0;
  logic [3:0] instr = 0;
  logic [W-1:0] shift_data = 0;
  logic [W-1:0] rd_data, live_cfg;
  logic secure, busy, cal_busy, pwr_down, out_en;

  jtag_cfg_cmd_ctrl #(.DATA_W(W), .BUSY_CYC(BC), .CAL_CYC(CC)) u0 (
    .clk(clk), .rst_n(rst_n), .upd_ir(upd_ir), .upd_dr(upd_dr), .rti_entry(rti_entry),
    .tlr(tlr), .instr(instr), .shift_data(shift_data), .rd_data(rd_data),
    .live_cfg(live_cfg), .secure(secure), .busy(busy), .cal_busy(cal_busy),
    .pwr_down(pwr_down), .out_en(out_en));

  always #2.5 clk = ~clk;

  int vectors = 0, errors = 0, wd = 0;
  bit done = 0;

  // behavioural reference model
  int m_cfg, m_sig, m_live, m_dreg, m_sec, m_pd, m_sel, m_bc, m_cc, m_pend;
  initial begin
    m_cfg = 0; m_sig = 0; m_live = 0; m_dreg = 0; m_sec = 0; m_pd = 0;
    m_sel = 0; m_bc = 0; m_cc = 0; m_pend = -1;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      int op, run;
      op = m_pend;
      run = (rti_entry && op > 0 && m_bc == 0);
      if (upd_dr) m_dreg = shift_data;
      if (tlr) m_pend = -1;
      else if (upd_ir) begin
        m_pend = (instr >= 1 && instr <= 11) ? int'(instr) : -1;
        if (instr == 12) m_sel = 0;
        if (instr == 13) m_sel = 1;
      end else if (rti_entry) m_pend = -1;
      if (m_bc > 0) m_bc--;
      if (m_cc > 0) m_cc--;
      if (run) begin
        if (op <= 6) m_bc = BC;
        case (op)
          1: m_cfg = m_cfg | m_dreg;
          2: m_sig = m_sig | m_dreg;
          3: m_sec = 1;
          4: m_cfg = 0;
          5: m_sig = 0;
          6: begin m_cfg = 0; m_sig = 0; m_sec = 0; end
          7, 8: m_live = m_cfg;
          9: m_pd = 0;
          10: m_pd = 1;
          11: if (m_cc == 0) m_cc = CC; else m_cc = m_cc;
          default: ;
        endcase
        if (op == 11 && m_cc == CC - 1) m_cc = m_cc;
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R2 rd_data", int'(rd_data), m_sel ? m_sig : (m_sec ? 0 : m_cfg));
      cmp("R7 live_cfg", int'(live_cfg), m_live);
      cmp("R6 secure", int'(secure), m_sec);
      cmp("R8 busy", int'(busy), int'(m_bc != 0));
      cmp("R10 cal_busy", int'(cal_busy), int'(m_cc != 0));
      cmp("R9 pwr_down", int'(pwr_down), m_pd);
      cmp("R9 out_en", int'(out_en), int'(!m_pd));
    end
  end

  task automatic pulse_ir(int op);
    @(posedge clk); #1; instr = 4'(op); upd_ir = 1;
    @(posedge clk); #1; upd_ir = 0;
  endtask
  task automatic pulse_dr(int v);
    @(posedge clk); #1; shift_data = W'(v); upd_dr = 1;
    @(posedge clk); #1; upd_dr = 0;
  endtask
  task automatic pulse_rti();
    @(posedge clk); #1; rti_entry = 1;
    @(posedge clk); #1; rti_entry = 0;
  endtask
  task automatic pulse_tlr();
    @(posedge clk); #1; tlr = 1;
    @(posedge clk); #1; tlr = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic run_cmd(int op);
    pulse_ir(op); pulse_rti(); idle(BC + 1);
  endtask
  task automatic chk(string tag, int act, int exp);
    @(negedge clk);
    cmp(tag, act, exp);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(1);
    chk("R11 reset rd_data", int'(rd_data), 0);
    chk("R11 reset out_en", int'(out_en), 1);
    // R1: deferred until Run-Test/Idle entry
    pulse_dr(16'h00F0); pulse_ir(1); idle(2);
    chk("R1 no effect at Update-IR", int'(rd_data), 0);
    pulse_rti();
    chk("R1 runs at rti entry", int'(rd_data), 16'h00F0);
    chk("R8 busy after program", int'(busy), 1);
    idle(BC + 1);
    // R3: OR accumulate
    pulse_dr(16'h0F01); run_cmd(1);
    chk("R3 program ORs", int'(rd_data), 16'h0FF1);
    // R2: read select
    pulse_dr(16'hA5A5); run_cmd(2);
    chk("R2 still reading cfg", int'(rd_data), 16'h0FF1);
    pulse_ir(13);
    chk("R2 sig selected", int'(rd_data), 16'hA5A5);
    // R7: latch then erase keeps live
    run_cmd(7);
    chk("R7 latch", int'(live_cfg), 16'h0FF1);
    run_cmd(4);
    chk("R4 erase cfg keeps sig", int'(rd_data), 16'hA5A5);
    chk("R7 erase keeps live", int'(live_cfg), 16'h0FF1);
    pulse_ir(12);
    chk("R4 cfg erased", int'(rd_data), 0);
    // R8: drop while busy
    pulse_dr(16'h1234); pulse_ir(1); pulse_rti();
    pulse_ir(5); pulse_rti(); idle(BC + 1);
    pulse_ir(13);
    chk("R8 erase-sig dropped", int'(rd_data), 16'hA5A5);
    // R7 reload
    run_cmd(8);
    chk("R7 reload", int'(live_cfg), 16'h1234);
    // R6 security
    run_cmd(3);
    chk("R6 secure set", int'(secure), 1);
    chk("R6 sig readable", int'(rd_data), 16'hA5A5);
    pulse_ir(12);
    chk("R6 cfg masked", int'(rd_data), 0);
    run_cmd(4); run_cmd(5);
    chk("R5 word erase keeps secure", int'(secure), 1);
    pulse_dr(16'h8001); run_cmd(1); run_cmd(2);
    run_cmd(6);
    chk("R5 bulk clears secure", int'(secure), 0);
    chk("R5 bulk clears cfg", int'(rd_data), 0);
    pulse_ir(13);
    chk("R5 bulk clears sig", int'(rd_data), 0);
    // R9 power
    pulse_ir(10); pulse_rti();
    chk("R9 powered down", int'(out_en), 0);
    pulse_ir(12);
    chk("R9 readback in power-down", int'(rd_data), 0);
    pulse_ir(9); pulse_rti();
    chk("R9 powered up", int'(out_en), 1);
    // R10 calibrate survives TLR
    pulse_ir(11); pulse_rti(); pulse_tlr(); idle(3);
    chk("R10 cal continues", int'(cal_busy), 1);
    pulse_ir(11); pulse_rti();
    idle(CC);
    chk("R10 cal ends", int'(cal_busy), 0);
    // R11 TLR discards pending
    pulse_ir(10); pulse_tlr(); pulse_rti(); idle(2);
    chk("R11 pending discarded", int'(pwr_down), 0);
    idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule